// File: doc/BRIEF.md
# Paired Predicate Loop-Bound Generator

This unit turns two 64-bit scalar loop bounds into a pair of predicate words for a vector loop. Each word holds one bit per byte of the vector, so the pair together covers twice the vector length. The unit first works out how many elements remain between the two bounds. It then marks that many elements active across the pair. Only the lowest bit of each element-sized group can ever be set.

Two directions are supported. In the incrementing direction, counting starts at element zero of the low word and continues into the bottom of the high word. In the decrementing direction, counting starts from the topmost element of the high word and spills down into the top of the low word. The bound comparison can be signed or unsigned. An inclusive option counts one extra element when the bounds meet.

Condition flags are derived from the two words read as one double-width predicate. Inputs are captured on a clock edge when `in_valid` is high. The words and flags appear one cycle later together with `out_valid`.

Top module: `pair_while_gen`

## Requirements
- R1: With `count_down`=0, the raw element count is op_b − op_a when op_a < op_b and 0 otherwise. When `inclusive`=1, the test is op_a ≤ op_b and the count is op_b − op_a + 1.
- R2: With `count_down`=1, the raw element count is op_a − op_b when op_a > op_b and 0 otherwise. When `inclusive`=1, the test is op_a ≥ op_b and the count is op_a − op_b + 1.
- R3: When `is_unsigned`=1, the operands compare as unsigned numbers. When it is 0, they compare as two's-complement signed numbers.
- R4: The element count saturates at (2·`vl_bytes`) >> `elem_size`. Element size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. Element k of the pair maps to bit k·2^`elem_size` of the double-width vector {pred_hi[vl-1:0], pred_lo[vl-1:0]}.
- R5: Only bit positions that are multiples of 2^`elem_size` can be set. Bits at index `vl_bytes` and above are zero in both words.
- R6: With `count_down`=0, elements 0 to count−1 of the pair are active. The low word fills first; any remainder goes to the high word starting from its bit 0.
- R7: With `count_down`=1, the top `count` elements of the pair are active. The high word fills from its top downwards; any remainder goes to the top of the low word.
- R8: `flag_n` is set when element 0 is active. `flag_z` is set when no element is active. `flag_c` is the inverse of the last element of the pair (at hi bit vl−2^esz) being active. `flag_v` is always 0.
- R9: The outputs update one cycle after an edge on which `in_valid` is high, and `out_valid` follows `in_valid` by one cycle. While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture the operands this cycle |
| op_a | input | 64 | First scalar bound |
| op_b | input | 64 | Second scalar bound |
| elem_size | input | 2 | Element size code (0..3 = 1,2,4,8 bytes) |
| vl_bytes | input | 9 | Vector length in bytes: a multiple of 16, from 16 up to MAX_VL |
| count_down | input | 1 | 0 = incrementing direction, 1 = decrementing direction |
| is_unsigned | input | 1 | 1 = unsigned comparison, 0 = signed comparison |
| inclusive | input | 1 | Count one extra element on equality |
| out_valid | output | 1 | Result valid |
| pred_lo | output | 256 | Low predicate word |
| pred_hi | output | 256 | High predicate word |
| flag_n | output | 1 | First element active |
| flag_z | output | 1 | No element active |
| flag_c | output | 1 | Last element not active |
| flag_v | output | 1 | Always zero |

## Verification
The bench builds the unit at its default MAX_VL of 256 bytes, so both 256-bit predicate words are exercised at their full width. Vector lengths are driven from 16 bytes up to 256 bytes. This brings within reach, for every element size in both directions, the spill point between the two words and full saturation of the pair. It also covers the flag corners where the first or last element changes state. Signed and unsigned bound pairs that straddle zero are mixed in, together with the widest inclusive span, so that the compare and overflow edges are reached.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
   typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } dir_e;
   localparam int OPW = 64;
   localparam int MIN_VL = 16;
endpackage

// File: rtl/pwg_count.sv
module pwg_count
   import pwg_pkg::*;
#(
   parameter int DW  = OPW,
   parameter int VLW = 9,
   parameter int CW  = VLW + 1
) (
   input  logic [DW-1:0]  op_a,
   input  logic [DW-1:0]  op_b,
   input  logic [1:0]     esz,
   input  logic [VLW-1:0] vl,
   input  dir_e           dir,
   input  logic           is_unsigned,
   input  logic           inclusive,
   output logic [CW-1:0]  bit_cnt,
   output logic [CW-1:0]  max_el
);
   logic [DW-1:0] a_key, b_key, big_op, small_op;
   logic          go;
   logic [DW:0]   span;
   logic [CW-1:0] el;

   always_comb begin
      a_key = op_a;
      b_key = op_b;
      if (!is_unsigned) begin
         a_key[DW-1] = ~op_a[DW-1];
         b_key[DW-1] = ~op_b[DW-1];
      end
      if (dir == DIR_DOWN) begin
         big_op   = op_a;
         small_op = op_b;
         go       = inclusive ? (a_key >= b_key) : (a_key > b_key);
      end else begin
         big_op   = op_b;
         small_op = op_a;
         go       = inclusive ? (b_key >= a_key) : (b_key > a_key);
      end
      span   = {1'b0, big_op - small_op} + {{DW{1'b0}}, inclusive};
      max_el = {vl, 1'b0} >> esz;
      if (!go)
         el = '0;
      else if (span > (DW+1)'(max_el))
         el = max_el;
      else
         el = span[CW-1:0];
      bit_cnt = el << esz;
   end
endmodule

// File: rtl/pwg_mask.sv
module pwg_mask
   import pwg_pkg::*;
#(
   parameter int MAX_VL = 256,
   parameter int VLW    = 9,
   parameter int CW     = VLW + 1
) (
   input  logic [CW-1:0]     bit_cnt,
   input  logic [1:0]        esz,
   input  logic [VLW-1:0]    vl,
   input  dir_e              dir,
   output logic [MAX_VL-1:0] lo,
   output logic [MAX_VL-1:0] hi
);
   localparam int IW = CW + 1;

   logic [IW-1:0] cnt_x, vl_x, dbl_x;
   assign cnt_x = IW'(bit_cnt);
   assign vl_x  = IW'(vl);
   assign dbl_x = IW'({vl, 1'b0});

   for (genvar i = 0; i < MAX_VL; i++) begin : g_bit
      localparam logic [IW-1:0] IDX = IW'(i);
      logic algn, live;
      always_comb begin
         case (esz)
            2'd0:    algn = 1'b1;
            2'd1:    algn = (i % 2) == 0;
            2'd2:    algn = (i % 4) == 0;
            default: algn = (i % 8) == 0;
         endcase
         live = algn && (IDX < vl_x);
         if (dir == DIR_DOWN) begin
            lo[i] = live && ((IDX + cnt_x) >= dbl_x);
            hi[i] = live && ((IDX + cnt_x) >= vl_x);
         end else begin
            lo[i] = live && (IDX < cnt_x);
            hi[i] = live && ((IDX + vl_x) < cnt_x);
         end
      end
   end
endmodule

// File: rtl/pwg_flags.sv
module pwg_flags #(
   parameter int MAX_VL = 256,
   parameter int VLW    = 9
) (
   input  logic [MAX_VL-1:0] lo,
   input  logic [MAX_VL-1:0] hi,
   input  logic [1:0]        esz,
   input  logic [VLW-1:0]    vl,
   output logic              n,
   output logic              z,
   output logic              c,
   output logic              v
);
   logic [VLW-1:0] last_idx;
   always_comb begin
      last_idx = vl - (VLW'(1) << esz);
      n = lo[0];
      z = ~(|lo) & ~(|hi);
      c = ~hi[last_idx[VLW-2:0]];
      v = 1'b0;
   end
endmodule

// File: rtl/pair_while_gen.sv
module pair_while_gen
   import pwg_pkg::*;
#(
   parameter int MAX_VL = 256,
   localparam int VLW   = $clog2(MAX_VL) + 1,
   localparam int CW    = VLW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPW-1:0]    op_a,
   input  logic [OPW-1:0]    op_b,
   input  logic [1:0]        elem_size,
   input  logic [VLW-1:0]    vl_bytes,
   input  logic              count_down,
   input  logic              is_unsigned,
   input  logic              inclusive,
   output logic              out_valid,
   output logic [MAX_VL-1:0] pred_lo,
   output logic [MAX_VL-1:0] pred_hi,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v
);
   if (MAX_VL < MIN_VL || (MAX_VL & (MAX_VL - 1)) != 0) begin : g_bad_vl
      $error("MAX_VL must be a power of two no smaller than %0d", MIN_VL);
   end

   dir_e              dir;
   logic [CW-1:0]     bit_cnt, max_el;
   logic [MAX_VL-1:0] lo_d, hi_d;
   logic              n_d, z_d, c_d, v_d;

   assign dir = count_down ? DIR_DOWN : DIR_UP;

   pwg_count #(.DW(OPW), .VLW(VLW), .CW(CW)) u_count (
      .op_a(op_a), .op_b(op_b), .esz(elem_size), .vl(vl_bytes), .dir(dir),
      .is_unsigned(is_unsigned), .inclusive(inclusive),
      .bit_cnt(bit_cnt), .max_el(max_el)
   );

   pwg_mask #(.MAX_VL(MAX_VL), .VLW(VLW), .CW(CW)) u_mask (
      .bit_cnt(bit_cnt), .esz(elem_size), .vl(vl_bytes), .dir(dir),
      .lo(lo_d), .hi(hi_d)
   );

   pwg_flags #(.MAX_VL(MAX_VL), .VLW(VLW)) u_flags (
      .lo(lo_d), .hi(hi_d), .esz(elem_size), .vl(vl_bytes),
      .n(n_d), .z(z_d), .c(c_d), .v(v_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pred_lo   <= '0;
         pred_hi   <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_c    <= 1'b0;
         flag_v    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pred_lo <= lo_d;
            pred_hi <= hi_d;
            flag_n  <= n_d;
            flag_z  <= z_d;
            flag_c  <= c_d;
            flag_v  <= v_d;
         end
      end
   end
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker #(
   parameter int MAX_VL = 256,
   localparam int VLW   = $clog2(MAX_VL) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        elem_size,
   input logic [VLW-1:0]    vl_bytes,
   input logic              count_down,
   input logic              out_valid,
   input logic [MAX_VL-1:0] pred_lo,
   input logic [MAX_VL-1:0] pred_hi,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_v
);
   logic [VLW-1:0] vl_q;
   logic [1:0]     esz_q;
   logic           down_q;
   logic [VLW-1:0] top_idx;
   logic           lo_top;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vl_q   <= VLW'(MAX_VL);
         esz_q  <= '0;
         down_q <= 1'b0;
      end else if (in_valid) begin
         vl_q   <= vl_bytes;
         esz_q  <= elem_size;
         down_q <= count_down;
      end
   end

   assign top_idx = vl_q - (VLW'(1) << esz_q);
   assign lo_top  = pred_lo[top_idx[VLW-2:0]];

   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));
   assert_no_bits_above_vl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((pred_lo | pred_hi) >> vl_q) == '0);
   assert_count_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({pred_hi, pred_lo}) <= (({1'b0, vl_q} << 1) >> esz_q));
   assert_up_fills_low_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !down_q && pred_hi != '0) |-> lo_top);
   assert_down_fills_high_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && down_q && pred_lo != '0) |-> pred_hi[0]);
   assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> flag_z == (pred_lo == '0 && pred_hi == '0));
   assert_first_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> flag_n == pred_lo[0]);
   assert_v_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_v);
endmodule

bind pair_while_gen pwg_checker #(.MAX_VL(MAX_VL)) u_pwg_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_size(elem_size),
   .vl_bytes(vl_bytes), .count_down(count_down), .out_valid(out_valid),
   .pred_lo(pred_lo), .pred_hi(pred_hi), .flag_n(flag_n), .flag_z(flag_z),
   .flag_v(flag_v)
);

// File: tb/test_pair_while_gen.sv
module test_pair_while_gen;
   localparam int CLK_PERIOD = 10;
   localparam int MAXV = 256;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [63:0]     op_a = '0, op_b = '0;
   logic [1:0]      elem_size = '0;
   logic [8:0]      vl_bytes = 9'd256;
   logic            count_down = 1'b0, is_unsigned = 1'b0, inclusive = 1'b0;
   logic            out_valid;
   logic [MAXV-1:0] pred_lo, pred_hi;
   logic            flag_n, flag_z, flag_c, flag_v;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pair_while_gen #(.MAX_VL(MAXV)) i_pair_while_gen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .elem_size(elem_size), .vl_bytes(vl_bytes), .count_down(count_down),
      .is_unsigned(is_unsigned), .inclusive(inclusive), .out_valid(out_valid),
      .pred_lo(pred_lo), .pred_hi(pred_hi), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [1:0] es, input int vl,
                                 input bit dn, input bit uns, input bit inc,
                                 output logic [MAXV-1:0] lo, output logic [MAXV-1:0] hi,
                                 output logic n, output logic z, output logic c);
      logic signed [65:0] sa, sb, d;
      int cnt, mx, p;
      bit on;
      sa = uns ? $signed({2'b00, a}) : $signed({{2{a[63]}}, a});
      sb = uns ? $signed({2'b00, b}) : $signed({{2{b[63]}}, b});
      d  = dn ? sa - sb : sb - sa;
      if (inc) d = d + 66'sd1;
      mx = (2 * vl) >> es;
      if (d <= 0) cnt = 0;
      else if (d > mx) cnt = mx;
      else cnt = int'(d);
      lo = '0;
      hi = '0;
      for (int k = 0; k < mx; k++) begin
         on = dn ? (k >= mx - cnt) : (k < cnt);
         p = k << es;
         if (on) begin
            if (p < vl) lo[p] = 1'b1;
            else hi[p - vl] = 1'b1;
         end
      end
      n = dn ? (cnt == mx && cnt > 0) : (cnt > 0);
      z = (cnt == 0);
      c = dn ? (cnt == 0) : (cnt != mx);
   endfunction

   task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] es,
                        input int vl, input bit dn, input bit uns, input bit inc,
                        input string req);
      logic [MAXV-1:0] elo, ehi;
      logic en, ez, ec;
      model(a, b, es, vl, dn, uns, inc, elo, ehi, en, ez, ec);
      @(negedge clk);
      op_a = a; op_b = b; elem_size = es; vl_bytes = 9'(vl);
      count_down = dn; is_unsigned = uns; inclusive = inc; in_valid = 1'b1;
      @(posedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b1 || pred_lo !== elo || pred_hi !== ehi ||
          flag_n !== en || flag_z !== ez || flag_c !== ec || flag_v !== 1'b0) begin
         errors++;
         $display("FAIL %s: a=%h b=%h esz=%0d vl=%0d dn=%0b uns=%0b inc=%0b act v=%b nzcv=%b%b%b%b lo=%h hi=%h exp v=1 nzcv=%b%b%b0 lo=%h hi=%h",
                  req, a, b, es, vl, dn, uns, inc, out_valid, flag_n, flag_z, flag_c, flag_v,
                  pred_lo, pred_hi, en, ez, ec, elo, ehi);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int w, c;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0 || pred_lo !== '0 || pred_hi !== '0 ||
          {flag_n, flag_z, flag_c, flag_v} !== 4'b0) begin
         errors++;
         $display("FAIL R9 reset: act v=%b lo=%h hi=%h exp all zero", out_valid, pred_lo, pred_hi);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R4 R6 R7: counts 0, one word, one word plus one element, full pair, beyond
      for (int es = 0; es < 4; es++) begin
         for (int vi = 0; vi < 2; vi++) begin
            for (int dn = 0; dn < 2; dn++) begin
               int vl;
               vl = (vi == 0) ? 16 : 256;
               w = vl >> es;
               for (int ci = 0; ci < 5; ci++) begin
                  case (ci)
                     0: c = 0;
                     1: c = w;
                     2: c = w + 1;
                     3: c = 2 * w;
                     default: c = 2 * w + 3;
                  endcase
                  if (dn == 1)
                     apply(64'(100 + c), 64'd100, 2'(es), vl, 1'b1, 1'b1, 1'b0, "R7");
                  else
                     apply(64'd100, 64'(100 + c), 2'(es), vl, 1'b0, 1'b1, 1'b0, "R6");
               end
            end
         end
      end

      // R3: operands straddling zero
      apply(-64'sd5, 64'd3, 2'd0, 64, 1'b0, 1'b0, 1'b0, "R3");
      apply(-64'sd5, 64'd3, 2'd0, 64, 1'b0, 1'b1, 1'b0, "R3");
      apply(64'd3, -64'sd5, 2'd1, 64, 1'b1, 1'b0, 1'b0, "R3");
      apply(64'd3, -64'sd5, 2'd1, 64, 1'b1, 1'b1, 1'b0, "R3");
      // R1 R2: inclusive equality and reversed bounds
      apply(64'd42, 64'd42, 2'd2, 128, 1'b0, 1'b1, 1'b1, "R1");
      apply(64'd42, 64'd42, 2'd2, 128, 1'b0, 1'b1, 1'b0, "R1");
      apply(64'd43, 64'd42, 2'd0, 128, 1'b0, 1'b0, 1'b1, "R1");
      apply(64'd42, 64'd42, 2'd3, 128, 1'b1, 1'b0, 1'b1, "R2");
      apply(64'd41, 64'd42, 2'd0, 128, 1'b1, 1'b1, 1'b0, "R2");
      // R4: widest inclusive spans
      apply(64'd0, '1, 2'd0, 256, 1'b0, 1'b1, 1'b1, "R4");
      apply(64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, 2'd3, 256, 1'b1, 1'b0, 1'b1, "R4");

      // R5 R8: random mix
      for (int k = 0; k < 400; k++) begin
         logic [63:0] a, d;
         int vl;
         vl = (($urandom % 16) + 1) * 16;
         a  = {$urandom, $urandom};
         d  = 64'($urandom % 600);
         if ($urandom % 2) d = -d;
         apply(a, a + d, 2'($urandom % 4), vl, 1'($urandom), 1'($urandom), 1'($urandom), "R5 R8");
      end

      // R9: no update without in_valid
      @(negedge clk);
      op_a = 64'd0; op_b = 64'd50; vl_bytes = 9'd32; count_down = 1'b0;
      @(posedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R9 idle: act v=%b exp v=0", out_valid);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule